// File: doc/BRIEF.md
# Direct-Page Pointer Address Generator

This block forms the 24-bit bus addresses a CPU core needs for direct-page operands and direct-page pointers. The core is 16-bit, but it can also run in an 8-bit compatible emulation state. From a start pulse it latches the direct register, the emulation flag, the 8-bit operand offset, both index registers and a 3-bit mode code. It then runs the byte fetches that the mode needs. Each fetch holds a read request and address until the memory side answers with ready and a data byte. When the fetches are complete, the block presents either the effective address or the assembled pointer and pulses done.

Direct and direct-indexed modes need no fetch. Their effective address is ready in the cycle after the start. The long-indirect modes read a three-byte pointer. The push-indirect mode reads a two-byte value. Which page-wrap rule applies depends on the mode, the emulation flag and the low byte of the direct register. The newer pointer modes always use plain 16-bit wrapping, so a pointer placed at offset FE or FF carries into the next page, even in emulation.

Top module: `dp_addr_gen`

## Requirements
- R1: After reset, rd_req, done and busy are low and result is zero.
- R2: Mode codes are: 0 direct, 1 direct indexed by X, 2 direct indexed by Y, 3 indirect long, 4 indirect long indexed by Y, 5 push-indirect, and 6 and 7 behave as direct. With emu=0, a direct-family mode gives result = (dpr + ofs + index) mod 0x10000 in bank 0x00, where the index is the whole 16-bit X or Y for codes 1 and 2 and zero for the others.
- R3: With emu=1 and dpr[7:0]=0, a direct-family result is {0x00, dpr[15:8], (ofs + index[7:0]) mod 0x100}, so it stays within one 256-byte page.
- R4: With emu=1 and dpr[7:0]≠0, a direct-family result is (dpr + ofs + index[7:0]) mod 0x10000 in bank 0x00.
- R5: Modes 3, 4 and 5 read byte i at address {0x00, (dpr + ofs + i) mod 0x10000}, whatever emu is. Bytes are read in rising order: low, high, then bank. Mode 5 reads two bytes and modes 3 and 4 read three.
- R6: In mode 3, result = {bank, high, low} of the fetched bytes.
- R7: In mode 4, result = ({bank, high, low} + Y) mod 0x1000000, so a carry from the index reaches the bank byte.
- R8: In mode 5, result = {0x00, high, low}.
- R9: While rd_req is high and rd_ready is low, rd_req stays high and rd_addr stays unchanged into the next cycle.
- R10: done is high for exactly one cycle. For modes with no fetch, it comes in the cycle after the start edge. For fetching modes, it comes in the cycle after the edge that accepts the last byte. rd_req is low while done is high.
- R11: A start while busy is high is ignored. The running operation completes with its original inputs.
- R12: Every address driven with rd_req high has its upper 8 bits equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only while idle |
| mode | input | 3 | Addressing-mode code (see R2) |
| emu | input | 1 | Emulation flag |
| dpr | input | 16 | Direct register |
| ofs | input | 8 | Operand offset |
| idx_x | input | 16 | X index value |
| idx_y | input | 16 | Y index value |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | 24 | Read address (zero when no request) |
| rd_ready | input | 1 | Memory accepts the request and rd_data is valid |
| rd_data | input | 8 | Returned byte |
| busy | output | 1 | Operation in progress, done cycle included |
| done | output | 1 | One-cycle completion pulse |
| result | output | 24 | Effective address or assembled pointer |

## Verification
Three situations are hard to reach from the ports. The first is the emulation case where a pointer begins at page offset FE or FF: only the third (or second) byte shows whether the carry into the next page was taken. The second is the difference between a zero and a nonzero low byte of the direct register. The third is a mode-4 index that overflows into the bank byte. The stimulus sweeps direct-register values whose low byte is zero or nonzero and whose high byte is 00 or FF, together with offsets FE, FF, 00, 01 and 7F, index values up to FFFF, both emulation states and all eight mode codes. The memory responder returns address-dependent bytes after zero, one or two wait cycles. On some operations it also raises start in the middle of a fetch with changed inputs.

// File: rtl/dp_addr_pkg.sv
package dp_addr_pkg;

    typedef enum logic [2:0] {
        MD_DIR        = 3'd0,
        MD_DIR_X      = 3'd1,
        MD_DIR_Y      = 3'd2,
        MD_IND_LONG   = 3'd3,
        MD_IND_LONG_Y = 3'd4,
        MD_PUSH_IND   = 3'd5,
        MD_RSV6       = 3'd6,
        MD_RSV7       = 3'd7
    } dp_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } dp_state_e;

    // Modes that read a pointer from the direct page
    function automatic logic is_ptr_mode(dp_mode_e m);
        return (m == MD_IND_LONG) || (m == MD_IND_LONG_Y) || (m == MD_PUSH_IND);
    endfunction

    // Index of the final byte fetched by a pointer mode
    function automatic logic [1:0] last_byte(dp_mode_e m);
        return (m == MD_PUSH_IND) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/dp_ea_calc.sv
// Combinational direct-page byte address with the mode-dependent wrap rule.
module dp_ea_calc #(
    parameter int WORD_W      = 16,
    parameter int BYTE_W      = 8,
    parameter bit EMU_WRAP_EN = 1'b1
) (
    input  logic [WORD_W-1:0] dpr,
    input  logic [BYTE_W-1:0] ofs,
    input  logic [WORD_W-1:0] idx,
    input  logic              emu,
    input  logic              force_native,
    input  logic [1:0]        byte_sel,
    output logic [WORD_W-1:0] addr
);
    localparam int HI_W = WORD_W - BYTE_W;

    logic [WORD_W-1:0] idx_eff;
    logic [WORD_W-1:0] wide_sum;
    logic [BYTE_W-1:0] page_low;
    logic              page_mode;

    // Emulation narrows the index to its low byte
    always_comb begin
        if (emu) idx_eff = {{HI_W{1'b0}}, idx[BYTE_W-1:0]};
        else     idx_eff = idx;
    end

    assign wide_sum = dpr + WORD_W'(ofs) + idx_eff + WORD_W'(byte_sel);
    assign page_low = ofs + idx_eff[BYTE_W-1:0] + BYTE_W'(byte_sel);

    generate
        if (EMU_WRAP_EN) begin : g_emu_wrap
            assign page_mode = emu && !force_native && (dpr[BYTE_W-1:0] == '0);
        end else begin : g_native_only
            assign page_mode = 1'b0;
        end
    endgenerate

    assign addr = page_mode ? {dpr[WORD_W-1:BYTE_W], page_low} : wide_sum;

endmodule

// File: rtl/dp_ptr_build.sv
// Assembles the fetched bytes into the mode's result.
module dp_ptr_build
    import dp_addr_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int BANK_W = 8
) (
    input  dp_mode_e                  mode,
    input  logic [BYTE_W-1:0]         lo,
    input  logic [BYTE_W-1:0]         hi,
    input  logic [BANK_W-1:0]         bk,
    input  logic [WORD_W-1:0]         yv,
    output logic [WORD_W+BANK_W-1:0]  result
);
    localparam int ADDR_W = WORD_W + BANK_W;
    localparam int PAD_W  = WORD_W - 2 * BYTE_W;

    logic [ADDR_W-1:0] ptr_long;
    logic [ADDR_W-1:0] ptr_word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ptr_long = {bk, {PAD_W{1'b0}}, hi, lo};
            assign ptr_word = {{BANK_W{1'b0}}, {PAD_W{1'b0}}, hi, lo};
        end else begin : g_nopad
            assign ptr_long = {bk, hi, lo};
            assign ptr_word = {{BANK_W{1'b0}}, hi, lo};
        end
    endgenerate

    always_comb begin
        case (mode)
            MD_IND_LONG_Y: result = ptr_long + ADDR_W'(yv);
            MD_PUSH_IND:   result = ptr_word;
            default:       result = ptr_long;
        endcase
    end

endmodule

// File: rtl/dp_addr_gen.sv
// Direct-page pointer address generator, top level.
module dp_addr_gen
    import dp_addr_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BYTE_W      = 8,
    parameter int BANK_W      = 8,
    parameter bit EMU_WRAP_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [2:0]                mode,
    input  logic                      emu,
    input  logic [WORD_W-1:0]         dpr,
    input  logic [BYTE_W-1:0]         ofs,
    input  logic [WORD_W-1:0]         idx_x,
    input  logic [WORD_W-1:0]         idx_y,
    output logic                      rd_req,
    output logic [WORD_W+BANK_W-1:0]  rd_addr,
    input  logic                      rd_ready,
    input  logic [BYTE_W-1:0]         rd_data,
    output logic                      busy,
    output logic                      done,
    output logic [WORD_W+BANK_W-1:0]  result
);
    localparam int ADDR_W = WORD_W + BANK_W;

    typedef struct packed {
        dp_state_e         st;
        dp_mode_e          md;
        logic              emu;
        logic [WORD_W-1:0] dpr;
        logic [BYTE_W-1:0] ofs;
        logic [WORD_W-1:0] idx;
        logic [WORD_W-1:0] yv;
        logic [1:0]        cnt;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
        logic [ADDR_W-1:0] res;
    } regs_t;

    regs_t r_q, r_d;

    dp_mode_e          mode_in;
    logic              idle;
    logic [WORD_W-1:0] idx_start;
    dp_mode_e          calc_md;
    logic [WORD_W-1:0] calc_dpr;
    logic [BYTE_W-1:0] calc_ofs;
    logic [WORD_W-1:0] calc_idx;
    logic              calc_emu;
    logic [1:0]        calc_sel;
    logic [WORD_W-1:0] word_addr;
    logic [BYTE_W-1:0] lo_now;
    logic [BYTE_W-1:0] hi_now;
    logic [ADDR_W-1:0] ptr_res;

    assign mode_in = dp_mode_e'(mode);
    assign idle    = (r_q.st == ST_IDLE);

    // Index chosen at start: only the indexed direct modes use one
    always_comb begin
        case (mode_in)
            MD_DIR_X: idx_start = idx_x;
            MD_DIR_Y: idx_start = idx_y;
            default:  idx_start = '0;
        endcase
    end

    // Address calculator reads the raw inputs when idle, latched state otherwise
    always_comb begin
        if (idle) begin
            calc_md  = mode_in;
            calc_dpr = dpr;
            calc_ofs = ofs;
            calc_idx = idx_start;
            calc_emu = emu;
            calc_sel = 2'd0;
        end else begin
            calc_md  = r_q.md;
            calc_dpr = r_q.dpr;
            calc_ofs = r_q.ofs;
            calc_idx = r_q.idx;
            calc_emu = r_q.emu;
            calc_sel = r_q.cnt;
        end
    end

    dp_ea_calc #(
        .WORD_W      (WORD_W),
        .BYTE_W      (BYTE_W),
        .EMU_WRAP_EN (EMU_WRAP_EN)
    ) u_ea (
        .dpr          (calc_dpr),
        .ofs          (calc_ofs),
        .idx          (calc_idx),
        .emu          (calc_emu),
        .force_native (is_ptr_mode(calc_md)),
        .byte_sel     (calc_sel),
        .addr         (word_addr)
    );

    // Merge the byte on the bus with the bytes already held
    assign lo_now = (r_q.cnt == 2'd0) ? rd_data : r_q.b0;
    assign hi_now = (r_q.cnt == 2'd1) ? rd_data : r_q.b1;

    dp_ptr_build #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .BANK_W (BANK_W)
    ) u_build (
        .mode   (r_q.md),
        .lo     (lo_now),
        .hi     (hi_now),
        .bk     (BANK_W'(rd_data)),
        .yv     (r_q.yv),
        .result (ptr_res)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.md  = mode_in;
                    r_d.emu = emu;
                    r_d.dpr = dpr;
                    r_d.ofs = ofs;
                    r_d.idx = idx_start;
                    r_d.yv  = idx_y;
                    r_d.cnt = 2'd0;
                    if (is_ptr_mode(mode_in)) begin
                        r_d.st = ST_FETCH;
                    end else begin
                        r_d.res = {{BANK_W{1'b0}}, word_addr};
                        r_d.st  = ST_DONE;
                    end
                end
            end
            ST_FETCH: begin
                if (rd_ready) begin
                    if (r_q.cnt == 2'd0) r_d.b0 = rd_data;
                    if (r_q.cnt == 2'd1) r_d.b1 = rd_data;
                    if (r_q.cnt == last_byte(r_q.md)) begin
                        r_d.res = ptr_res;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.cnt = r_q.cnt + 2'd1;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req  = (r_q.st == ST_FETCH);
    assign rd_addr = rd_req ? {{BANK_W{1'b0}}, word_addr} : '0;
    assign done    = (r_q.st == ST_DONE);
    assign busy    = !idle;
    assign result  = r_q.res;

endmodule

// File: rtl/dp_addr_gen_chk.sv
module dp_addr_gen_chk #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ready,
    input logic              busy,
    input logic              done
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));   // R9

    AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[ADDR_W-1:WORD_W] == '0));             // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R10

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);                                         // R10

    AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=>
        (!rd_req || (rd_addr[WORD_W-1:0] == $past(rd_addr[WORD_W-1:0]) + 16'd1))); // R5

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);                                // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !done));                             // R1
endmodule

bind dp_addr_gen dp_addr_gen_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ready (rd_ready),
    .busy     (busy),
    .done     (done)
);

// File: tb/dp_addr_gen_test.sv
module dp_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        emu = 1'b0;
    logic [15:0] dpr = 16'h0;
    logic [7:0]  ofs = 8'h0;
    logic [15:0] idx_x = 16'h0;
    logic [15:0] idx_y = 16'h0;
    logic        rd_req;
    logic [23:0] rd_addr;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data = 8'h0;
    logic        busy;
    logic        done;
    logic [23:0] result;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dp_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .emu(emu),
        .dpr(dpr), .ofs(ofs), .idx_x(idx_x), .idx_y(idx_y),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data), .busy(busy), .done(done), .result(result)
    );

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5 ^ a[23:16];
    endfunction

    task automatic check(input bit ok, input string req, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] m, input logic e, input logic [15:0] d,
                          input logic [7:0] o, input logic [15:0] x,
                          input logic [15:0] y, input int wsel, input bit poke);
        int          nb;
        int          bi;
        int          wc;
        int          cyc;
        logic [15:0] ix;
        logic [23:0] exp_res;
        logic [23:0] held;
        logic [7:0]  got [3];
        string       rq;
        nb = (m == 3'd3 || m == 3'd4) ? 3 : (m == 3'd5) ? 2 : 0;
        @(negedge clk);
        mode = m; emu = e; dpr = d; ofs = o; idx_x = x; idx_y = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bi = 0; wc = 0; cyc = 0; held = '0;
        while (!done && cyc < 40) begin
            if (rd_req) begin
                if (wc == 0) begin
                    held = rd_addr;
                    check(rd_addr == {8'h00, d + 16'(o) + 16'(bi)}, "R5", rd_addr,
                          {8'h00, d + 16'(o) + 16'(bi)});
                end else begin
                    check(rd_addr == held, "R9", rd_addr, held);
                end
                if (poke && bi == 0 && wc == 0) begin
                    start = 1'b1; mode = 3'd0; dpr = ~d; ofs = ~o; emu = ~e;
                end
                if (wc >= wsel) begin
                    rd_ready = 1'b1;
                    rd_data = memf(rd_addr);
                    if (bi < 3) got[bi] = rd_data;
                    bi++;
                    wc = 0;
                end else begin
                    rd_ready = 1'b0;
                    wc++;
                end
            end else begin
                rd_ready = 1'b0;
            end
            @(negedge clk);
            start = 1'b0;
            rd_ready = 1'b0;
            cyc++;
        end
        check(done == 1'b1, "R10", 24'(done), 24'd1);
        check(bi == nb, "R5", 24'(bi), 24'(nb));
        if (nb == 0) begin
            check(cyc == 0, "R10", 24'(cyc), 24'd0);
            ix = (m == 3'd1) ? x : (m == 3'd2) ? y : 16'h0;
            if (e) ix = {8'h00, ix[7:0]};
            if (!e) begin
                rq = "R2"; exp_res = {8'h00, d + 16'(o) + ix};
            end else if (d[7:0] == 8'h00) begin
                rq = "R3"; exp_res = {8'h00, d[15:8], o + ix[7:0]};
            end else begin
                rq = "R4"; exp_res = {8'h00, d + 16'(o) + ix};
            end
        end else if (m == 3'd5) begin
            rq = "R8"; exp_res = {8'h00, got[1], got[0]};
        end else if (m == 3'd3) begin
            rq = "R6"; exp_res = {got[2], got[1], got[0]};
        end else begin
            rq = "R7"; exp_res = {got[2], got[1], got[0]} + {8'h00, y};
        end
        if (poke) rq = {rq, "/R11"};
        check(result == exp_res, rq, result, exp_res);
        @(negedge clk);
        check(!done && !busy && !rd_req, "R10", {21'h0, done, busy, rd_req}, 24'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [15:0] dl [6];
        logic [7:0]  ol [5];
        logic [15:0] xl [4];
        dl = '{16'h0000, 16'h0100, 16'hFF00, 16'h0034, 16'hFFFF, 16'h12FF};
        ol = '{8'h00, 8'h01, 8'h7F, 8'hFE, 8'hFF};
        xl = '{16'h0000, 16'h00FF, 16'h1234, 16'hFFFF};
        repeat (3) @(negedge clk);
        check(!rd_req && !done && !busy && result == 24'h0, "R1",
              {result[20:0], rd_req, done, busy}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req && !done && !busy && result == 24'h0, "R1",
              {result[20:0], rd_req, done, busy}, 24'h0);
        // Directed: emulation, D=0, long pointer at FE must read 0x000100 last (R5)
        run_op(3'd3, 1'b1, 16'h0000, 8'hFE, 16'h0, 16'h0, 1, 1'b0);
        // Directed: Y carry into the bank byte (R7)
        run_op(3'd4, 1'b1, 16'hFF00, 8'hFD, 16'h0, 16'hFFFF, 0, 1'b0);
        for (int di = 0; di < 6; di++)
            for (int oi = 0; oi < 5; oi++)
                for (int xi = 0; xi < 4; xi++)
                    for (int e = 0; e < 2; e++)
                        for (int m = 0; m < 8; m++)
                            run_op(3'(m), 1'(e), dl[di], ol[oi], xl[xi],
                                   xl[xi] ^ 16'h0F0F, (di + oi + xi + m) % 3,
                                   (di == 1 && xi == 2));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule